// File: doc/BRIEF.md
# Multiplexed Byte Bus Cycle Controller

This block sits between a processor core with a 16-bit internal datapath and an external bus that has only eight data lines and a 20-bit address. The core hands over one transfer at a time: a read or a write, a byte or a 16-bit word, aimed at memory or at the I/O space. The block turns it into one or two byte-wide bus cycles. Each cycle puts the low address byte and then the data on one shared set of pins. The middle address byte has its own pins. The four top pins carry the high address nibble first and then a status nibble.

Every byte cycle runs through four states. T1 drives the address and a one-cycle latch-enable pulse. T2 and T3 assert the read or write strobe. Wait states follow T3 for as long as the device holds `ready` low. T4 releases the strobe. A word is split into the low byte at the given address and then the high byte at the next address. When the last byte cycle is over, a single-cycle response carries the assembled read data back to the core.

The request side is a valid/ready stream. `req_ready` is high only while the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a transfer is in flight, `req_ready` stays low and every request input is ignored, so the core must hold its request until it is taken. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the core must accept.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `rd_n`=`wr_n`=1, `ale`=0, `ad_oe`=0, `rsp_valid`=0. `req_ready` is 1 only while idle. The cycle after an accepting edge is T1, and `req_ready` is then 0.
- R2: In T1, `ale`=1 for exactly one cycle, `ad_oe`=1 and `ad_out` = address bits 7..0. `a_hi_st` = address bits 19..16 for memory and 0 for I/O.
- R3: `a_mid` = address bits 15..8 and stays unchanged from T1 through T4 of each byte cycle.
- R4: From T2 through T4, `a_hi_st` carries status: bit 0 = write, bit 1 = I/O, bit 2 = second byte of a word, bit 3 = 0. `io_sel` = 1 for I/O for the whole byte cycle.
- R5: In a read, `rd_n`=0 in T2, T3 and every wait state, `wr_n` stays 1, and `ad_oe`=0 from T2 through T4. The two strobes are never both low.
- R6: In a write, `wr_n`=0 in T2, T3 and every wait state, and `ad_oe`=1 with `ad_out` = the data byte from T2 through T4.
- R7: `ready` is sampled at the end of T3 and of each wait state. When it is low, another wait state follows with the strobe still asserted. When it is high, T4 follows. The strobe therefore stays low for exactly 2 + N cycles for N low samples.
- R8: Read data is taken from `ad_in` at the edge where `ready` is sampled high.
- R9: A word access does the byte at the given address first and the byte at address+1 (modulo 2^20) second. The second T1 follows the first T4 directly. For writes, data bits 7..0 go in the first byte cycle and bits 15..8 in the second.
- R10: `rsp_valid` is high for one cycle, the cycle after the last T4. `rsp_rdata` is {high byte, low byte} for a word read, {8'h00, byte} for a byte read, and 0 for a write.
- R11: Request inputs that change or pulse `req_valid` while the block is busy have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (bits 7..0 for a byte) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| ad_out | output | 8 | Shared pins, out: low address byte, then write data |
| ad_oe | output | 1 | Output enable for the shared pins |
| ad_in | input | 8 | Shared pins, in: read data |
| a_mid | output | 8 | Address bits 15..8 |
| a_hi_st | output | 4 | Address bits 19..16 in T1, status afterwards |
| io_sel | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| ale | output | 1 | Address latch enable, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ready | input | 1 | Device ready, sampled at end of T3 and wait states |

## Verification
T1 appears one cycle after the accepting edge and the strobe falls in the second cycle. With N wait samples, T4 comes 4+N cycles after acceptance. A byte response is due 5+N cycles after acceptance, and a word response 9+N1+N2 cycles after. A device model samples every pin at the falling clock edge and follows the state sequence from the `ale` pulse. It checks each pin against the phase it expects and counts strobe cycles against the wait count it chose. It also requires `rsp_valid` in exactly the cycle after the last T4, and it compares the response against a scoreboard queue that the driver filled from its own memory model.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4
  } tstate_e;

  typedef struct packed {
    logic write;
    logic word;
    logic io;
  } kind_t;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    word,
  input  logic    ready,
  output tstate_e state,
  output logic    second,
  output logic    sample,
  output logic    done
);
  logic more_bytes;

  assign more_bytes = word && !second;
  assign sample     = (state == ST_T3 || state == ST_TW) && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      second <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) state <= ST_T1;
        ST_T1:   state <= ST_T2;
        ST_T2:   state <= ST_T3;
        ST_T3, ST_TW: state <= ready ? ST_T4 : ST_TW;
        ST_T4: begin
          if (more_bytes) begin
            state  <= ST_T1;
            second <= 1'b1;
          end else begin
            state  <= ST_IDLE;
            second <= 1'b0;
            done   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbus_addr.sv
module mbus_addr
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [2*BUS_W-1:0]          req_wdata,
  input  kind_t                       req_kind,
  input  tstate_e                     state,
  input  logic                        second,
  output kind_t                       kind_q,
  output logic [BUS_W-1:0]            ad_out,
  output logic                        ad_oe,
  output logic [BUS_W-1:0]            a_mid,
  output logic [ADDR_W-2*BUS_W-1:0]   a_hi_st,
  output logic                        io_sel,
  output logic                        ale,
  output logic                        rd_n,
  output logic                        wr_n
);
  localparam int HI_W = ADDR_W - 2*BUS_W;

  logic [ADDR_W-1:0]  addr_q;
  logic [2*BUS_W-1:0] wdata_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [BUS_W-1:0]   data_byte;
  logic [HI_W-1:0]    status;
  logic               busy, in_t1, strobe_ph, data_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      kind_q  <= req_kind;
    end
  end

  assign cur_addr  = addr_q + ADDR_W'(second);
  assign data_byte = second ? wdata_q[2*BUS_W-1:BUS_W] : wdata_q[BUS_W-1:0];

  assign busy      = (state != ST_IDLE);
  assign in_t1     = (state == ST_T1);
  assign strobe_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign data_ph   = strobe_ph || (state == ST_T4);

  always_comb begin
    status    = '0;
    status[0] = kind_q.write;
    status[1] = kind_q.io;
    status[2] = second;
  end

  always_comb begin
    ad_oe   = in_t1 || (kind_q.write && data_ph);
    ad_out  = '0;
    a_hi_st = '0;
    if (in_t1) begin
      ad_out  = cur_addr[BUS_W-1:0];
      a_hi_st = kind_q.io ? '0 : cur_addr[ADDR_W-1:2*BUS_W];
    end else if (data_ph) begin
      if (kind_q.write) ad_out = data_byte;
      a_hi_st = status;
    end
  end

  assign a_mid  = busy ? cur_addr[2*BUS_W-1:BUS_W] : '0;
  assign io_sel = busy && kind_q.io;
  assign ale    = in_t1;
  assign rd_n   = !(strobe_ph && !kind_q.write);
  assign wr_n   = !(strobe_ph && kind_q.write);
endmodule

// File: rtl/mbus_rdasm.sv
module mbus_rdasm #(
  parameter int BUS_W = 8,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   sample,
  input  logic                   second,
  input  logic                   write,
  input  logic                   word,
  input  logic [BUS_W-1:0]       ad_in,
  output logic [LANES*BUS_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    logic             hit;

    assign hit = sample && (int'(second) == g);

    always_ff @(posedge clk) begin
      if (rst || start) lane_q <= '0;
      else if (hit)     lane_q <= ad_in;
    end

    if (g == 0) begin : g_low
      assign rdata[BUS_W-1:0] = write ? '0 : lane_q;
    end else begin : g_up
      assign rdata[g*BUS_W +: BUS_W] = (write || !word) ? '0 : lane_q;
    end
  end
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic                      req_io,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [2*BUS_W-1:0]        req_wdata,
  output logic                      rsp_valid,
  output logic [2*BUS_W-1:0]        rsp_rdata,
  output logic [BUS_W-1:0]          ad_out,
  output logic                      ad_oe,
  input  logic [BUS_W-1:0]          ad_in,
  output logic [BUS_W-1:0]          a_mid,
  output logic [ADDR_W-2*BUS_W-1:0] a_hi_st,
  output logic                      io_sel,
  output logic                      ale,
  output logic                      rd_n,
  output logic                      wr_n,
  input  logic                      ready
);
  tstate_e state;
  kind_t   req_kind, kind_q;
  logic    start, second, sample;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign req_kind  = '{write: req_write, word: req_word, io: req_io};

  mbus_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .word   (kind_q.word),
    .ready  (ready),
    .state  (state),
    .second (second),
    .sample (sample),
    .done   (rsp_valid)
  );

  mbus_addr #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_kind  (req_kind),
    .state     (state),
    .second    (second),
    .kind_q    (kind_q),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_mid     (a_mid),
    .a_hi_st   (a_hi_st),
    .io_sel    (io_sel),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  mbus_rdasm #(.BUS_W(BUS_W), .LANES(2)) u_rdasm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .sample (sample),
    .second (second),
    .write  (kind_q.write),
    .word   (kind_q.word),
    .ad_in  (ad_in),
    .rdata  (rsp_rdata)
  );
endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             ad_oe,
  input logic [BUS_W-1:0] a_mid,
  input logic             ready
);
  AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (ale && !req_ready)); // R1
  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R2
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> $stable(a_mid)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n)); // R5
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(rd_n && wr_n) && !$past(rd_n && wr_n) && !ready) |=> !(rd_n && wr_n)); // R7
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R10
endmodule

bind mbus_ctrl mbus_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .a_mid     (a_mid),
  .ready     (ready)
);

// File: tb/mbus_ctrl_bench.sv
module mbus_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [7:0]  ad_out, a_mid;
  logic [7:0]  ad_in = '0;
  logic [3:0]  a_hi_st;
  logic        ad_oe, io_sel, ale, rd_n, wr_n;
  logic        ready = 1'b1;

  mbus_ctrl u_mbus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_io(req_io),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a_mid(a_mid), .a_hi_st(a_hi_st), .io_sel(io_sel), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        io;
    logic        write;
    logic        second;
    logic        last;
    logic [19:0] addr;
    logic [7:0]  data;
    int          waits;
  } beat_t;

  beat_t       beat_q[$];
  logic [15:0] rsp_q[$];
  logic [7:0]  mem[int];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int key_of(input logic io, input logic [19:0] a);
    return io ? (32'h100000 | int'(a[15:0])) : int'(a);
  endfunction

  function automatic logic [7:0] model_rd(input int k);
    if (mem.exists(k)) return mem[k];
    return k[7:0] ^ k[15:8] ^ 8'h5A;
  endfunction

  // Driver: pushes expectations, then offers the request
  task automatic do_req(input logic w, input logic wd, input logic io,
                        input logic [19:0] a, input logic [15:0] d,
                        input int w0, input int w1, input bit scribble);
    beat_t       b0, b1;
    logic [19:0] a1;
    logic [15:0] exp;
    a1 = a + 20'd1;
    if (io) a1 = {4'h0, a1[15:0]};
    b0 = '{io: io, write: w, second: 1'b0, last: !wd, addr: a, data: d[7:0], waits: w0};
    b1 = '{io: io, write: w, second: 1'b1, last: 1'b1, addr: a1, data: d[15:8], waits: w1};
    beat_q.push_back(b0);
    if (wd) beat_q.push_back(b1);
    if (w) exp = 16'h0000;
    else if (wd) exp = {model_rd(key_of(io, a1)), model_rd(key_of(io, a))};
    else exp = {8'h00, model_rd(key_of(io, a))};
    rsp_q.push_back(exp);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_word = wd; req_io = io;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    if (scribble) begin
      // R11: garbage request while busy must be ignored
      req_write = !w; req_word = !wd; req_io = !io;
      req_addr = ~a; req_wdata = ~d;
      for (int i = 0; i < 2; i++) begin
        check(req_ready == 1'b0, "R1 R11 ready while busy", req_ready, 0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (rsp_q.size() != 0 || beat_q.size() != 0) @(negedge clk);
  endtask

  // Device model and monitor
  beat_t cur;
  bit    active = 0, prev_strobe = 0, exp_rsp = 0, exp_ale = 0;
  int    scnt = 0;
  logic [7:0] mid_l;

  always @(negedge clk) begin
    if (!rst) begin
      if (exp_rsp) check(rsp_valid == 1'b1, "R10 response timing", rsp_valid, 1);
      else if (rsp_valid) check(1'b0, "R10 unexpected response", rsp_valid, 0);
      exp_rsp = 0;
      if (rsp_valid) begin
        if (rsp_q.size() == 0) check(1'b0, "R10 response with empty queue", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = rsp_q.pop_front();
          check(rsp_rdata == e, "R8 R10 response data", rsp_rdata, e);
        end
      end

      if (exp_ale) check(ale == 1'b1, "R9 second T1 follows T4", ale, 1);
      exp_ale = 0;

      if (ale) begin
        if (beat_q.size() == 0) check(1'b0, "R2 unexpected T1", 0, 1);
        else begin
          logic [19:0] ea;
          cur = beat_q.pop_front();
          ea = cur.io ? {4'h0, cur.addr[15:0]} : cur.addr;
          check({a_hi_st, a_mid, ad_out} == ea && ad_oe, "R2 R9 T1 address",
                {a_hi_st, a_mid, ad_out}, ea);
          check(io_sel == cur.io, "R4 io_sel in T1", io_sel, cur.io);
          active = 1; scnt = 0; prev_strobe = 0; mid_l = a_mid;
        end
        ready = 1'b1;
      end else if (active) begin
        bit strobe;
        check(a_mid == mid_l, "R3 middle address held", a_mid, mid_l);
        check(a_hi_st == {1'b0, cur.second, cur.io, cur.write} && io_sel == cur.io,
              "R4 status nibble", {io_sel, a_hi_st}, {cur.io, 1'b0, cur.second, cur.io, cur.write});
        strobe = !rd_n || !wr_n;
        if (strobe) begin
          scnt++;
          if (!cur.write) begin
            check(!ad_oe && wr_n, "R5 read strobe phase", {ad_oe, wr_n}, 2'b01);
            ad_in = model_rd(key_of(cur.io, cur.addr));
          end else begin
            check(ad_oe && rd_n && ad_out == cur.data, "R6 write data phase",
                  {ad_oe, rd_n, ad_out}, {2'b11, cur.data});
          end
          ready = (scnt >= 2 + cur.waits);
        end else if (prev_strobe) begin
          check(scnt == 2 + cur.waits, "R7 strobe length", scnt, 2 + cur.waits);
          if (cur.write) begin
            check(ad_oe && ad_out == cur.data, "R6 data held in T4",
                  {ad_oe, ad_out}, {1'b1, cur.data});
            mem[key_of(cur.io, cur.addr)] = ad_out;
          end else begin
            check(!ad_oe, "R5 pins float in T4", ad_oe, 0);
          end
          active = 0;
          if (cur.last) exp_rsp = 1; else exp_ale = 1;
          ready = 1'b1;
        end else begin
          check(1'b0, "R5 R6 strobe missing in T2", {rd_n, wr_n}, 0);
        end
        prev_strobe = strobe;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rd_n && wr_n && !ale && !ad_oe && !rsp_valid, "R1 reset outputs",
          {rd_n, wr_n, ale, ad_oe, rsp_valid}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 idle ready", req_ready, 1);

    do_req(0, 0, 0, 20'h12345, 16'h0000, 0, 0, 0);        // R8 byte read
    do_req(1, 0, 0, 20'h12345, 16'h00A5, 1, 0, 0);        // R6 byte write, one wait
    do_req(0, 0, 0, 20'h12345, 16'h0000, 3, 0, 0);        // R7 read back, three waits
    do_req(1, 1, 0, 20'hFFFFF, 16'hBEEF, 0, 2, 0);        // R9 word write across wrap
    do_req(0, 1, 0, 20'hFFFFF, 16'h0000, 2, 0, 0);        // R9 word read across wrap
    do_req(1, 0, 1, 20'h00380, 16'h003C, 0, 0, 0);        // R4 I/O write
    do_req(0, 0, 1, 20'h00380, 16'h0000, 1, 0, 0);        // R2 I/O read, top pins zero
    do_req(0, 1, 1, 20'h003F8, 16'h0000, 0, 4, 0);        // R4 I/O word read
    do_req(0, 1, 0, 20'hA0F0E, 16'h0000, 1, 1, 1);        // R11 scribble during word read
    do_req(1, 1, 0, 20'h40000, 16'h1234, 0, 0, 1);        // R11 scribble during word write
    do_req(0, 1, 0, 20'h40000, 16'h0000, 0, 0, 0);        // R10 word assembly
    repeat (3) @(negedge clk);
    check(req_ready && rd_n && wr_n && !ad_oe, "R1 back to idle",
          {req_ready, rd_n, wr_n, ad_oe}, 4'b1110);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule